// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned W-bit operands over several clock cycles. It uses a small controller with three states and a datapath made of a multiplicand register, an accumulator with a carry bit, a multiplier register that also collects the low half of the result, and a down counter that tracks the remaining iterations. A pulse on `go` while the block is idle captures both operands and starts the operation. The block then alternates two states. In the first, it adds the multiplicand into the accumulator when the multiplier's least significant bit is one. In the second, it shifts the combined carry, accumulator and multiplier word right by one place.

When the counter reaches zero the loop ends and the block returns to idle. The full 2W-bit product is then on `product`, and `done` is high for that one cycle. The product stays on the output until the next accepted start. A new start may be given in the same cycle as `done`.

Top module: `seq_mult`

## Requirements
- R1: After reset, `busy` and `done` are low and `product` is zero.
- R2: A high `go` sampled while idle starts an operation. `busy` is high for exactly 2*W cycles, beginning in the cycle after the start, and then falls.
- R3: When an operation ends, `product` equals the unsigned product of the two operands captured at the start, as a full 2W-bit result.
- R4: The carry out of each addition is kept and shifted into the accumulator. Products whose partial sums overflow W bits, such as the largest operand squared, are therefore exact.
- R5: The loop runs exactly W add/shift iterations. The zero test is made on the counter value before it is decremented.
- R6: `done` is high for exactly one cycle: the first idle cycle after an operation, which is also the first cycle in which the final product is shown.
- R7: While idle with `go` low, the block stays idle and `product` does not change.
- R8: While busy, changes on `go`, `mcand_in` and `mplier_in` do not affect the result or the timing.
- R9: A start given in the same cycle that `done` is high is accepted, so operations can run back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start request, sampled while idle |
| mcand_in | input | W | Multiplicand operand |
| mplier_in | input | W | Multiplier operand |
| product | output | 2*W | Result: accumulator in the high half, multiplier register in the low half |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse marking a finished operation |

## Verification
The bench targets operand pairs that stress the carry path. With the largest operands squared, a design that dropped the carry bit would lose the top bit of each partial sum and return a wrong high half. Zero and one operands expose an off-by-one in the loop count: one iteration too many or too few shifts the result by a bit and also moves `done` by two cycles against the reference. Operands and `go` are scrambled while the block is busy, so a design that reloaded its registers mid-run or restarted would be caught. Starts issued in the same cycle as `done` check that no idle gap is required between operations.

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic [2*W-1:0] product,
  output logic           busy,
  output logic           done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(W - 1);

  typedef enum logic [1:0] {S_IDLE = 2'b00, S_ADD = 2'b01, S_SHIFT = 2'b10} st_t;

  st_t           st;
  logic [W-1:0]  mcand, acc, mplier;
  logic          carry;
  logic [CW-1:0] cnt;

  wire       zero = (cnt == '0);
  wire [W:0] sum  = {1'b0, acc} + {1'b0, mcand};

  assign product = {acc, mplier};
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mcand  <= '0;
      acc    <= '0;
      mplier <= '0;
      carry  <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          carry  <= 1'b0;
          acc    <= '0;
          cnt    <= CNT_INIT;
          mcand  <= mcand_in;
          mplier <= mplier_in;
          st     <= S_ADD;
        end
        S_ADD: begin
          if (mplier[0]) {carry, acc} <= sum;
          st <= S_SHIFT;
        end
        S_SHIFT: begin
          {carry, acc, mplier} <= {1'b0, carry, acc, mplier[W-1:1]};
          cnt <= cnt - 1'b1;
          if (zero) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            st <= S_ADD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    st != 2'b11); // R5
  AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && go) |=> (st == S_ADD && busy)); // R2
  AST_ADD_THEN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADD) |=> (st == S_SHIFT)); // R5
  AST_CARRY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT) |=> !carry); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !go) |=> ($stable(product) && !busy)); // R7
  AST_OPERAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(mcand)); // R8
endmodule

// File: tb/test_seq_mult.sv
module test_seq_mult;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           go = 1'b0;
  logic [W-1:0]   mcand_in = '0;
  logic [W-1:0]   mplier_in = '0;
  logic [2*W-1:0] product;
  logic           busy, done;

  seq_mult #(.W(W)) i_seq_mult (
    .clk(clk), .rst_n(rst_n), .go(go), .mcand_in(mcand_in),
    .mplier_in(mplier_in), .product(product), .busy(busy), .done(done)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  int             left = 0;
  logic [2*W-1:0] m_prod = '0;
  logic [2*W-1:0] pend = '0;
  bit             m_done = 1'b0;
  string          cur_tag = "R3";

  task automatic chk(input bit ok, input string req, input logic [2*W-1:0] act,
                     input logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit g, input logic [W-1:0] a, input logic [W-1:0] b);
    chk(busy === (left != 0), "R2 R5 busy", {15'd0, busy}, {15'd0, left != 0});
    chk(done === m_done, "R6 done", {15'd0, done}, {15'd0, m_done});
    if (left == 0) chk(product === m_prod, cur_tag, product, m_prod);
    go = g; mcand_in = a; mplier_in = b;
    if (left == 0) begin
      m_done = 1'b0;
      if (g) begin
        left = 2 * W;
        pend = (2*W)'(a) * (2*W)'(b);
      end
    end else begin
      left--;
      m_done = (left == 0);
      if (left == 0) m_prod = pend;
    end
    @(negedge clk);
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input string tag, input bit noisy);
    cur_tag = tag;
    step(1'b1, a, b);
    while (left > 0) begin
      if (noisy) step(1'($urandom), W'($urandom), W'($urandom));
      else step(1'b0, a, b);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 busy", {15'd0, busy}, 16'd0);
    chk(done === 1'b0, "R1 done", {15'd0, done}, 16'd0);
    chk(product === '0, "R1 product", product, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cur_tag = "R7 idle";
    repeat (4) step(1'b0, 8'hA5, 8'h5A);
    run_op(8'd12, 8'd13, "R3 basic", 1'b0);
    run_op(8'hFF, 8'hFF, "R4 carry max", 1'b0);
    run_op(8'd0, 8'hFF, "R5 zero", 1'b0);
    run_op(8'd1, 8'd1, "R5 one", 1'b0);
    run_op(8'h80, 8'h02, "R3 shift", 1'b0);
    run_op(8'hFF, 8'h01, "R4 carry", 1'b1);
    cur_tag = "R7 hold";
    repeat (5) step(1'b0, 8'h33, 8'h77);
    run_op(8'hC3, 8'hF7, "R8 noisy", 1'b1);
    run_op(8'h9D, 8'h6B, "R9 back to back", 1'b1);
    for (int i = 0; i < 40; i++) begin
      run_op(W'($urandom), W'($urandom), "R3 R8 random", 1'b1);
      if (i % 3 == 0) begin
        cur_tag = "R7 random idle";
        repeat (2) step(1'b0, W'($urandom), W'($urandom));
      end
    end
    cur_tag = "R7 final";
    repeat (3) step(1'b0, '0, '0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule